// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the management registers of an Ethernet PHY over a two-wire serial management bus (MDC clock, MDIO data). The host sees two registers. The command register packs the target PHY number, the register number inside the PHY, a clock-range code, a write/read selector and a go/busy flag. The data register carries 16 bits: the value to write, or the value read back.

To write, the host first loads the data register. It then writes the command register with the go flag set and the write selector set. To read, it writes the command register with the go flag set and the write selector clear. The block then sends one 64-bit management frame, MSB first, on MDC/MDIO. The flag reads back as busy until the frame has finished. After a read, the captured 16-bit value is in the data register once busy has cleared.

The clock-range code sets the MDC half period as a multiple of the system clock. The pin is split into output value, output enable and input, so that the pad cell outside the block forms the bidirectional line.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After a synchronous active-low reset, MDC is low, the output enable is low, and both registers read as zero.
- R2: A command-register write (select 0) with bit 0 set starts a frame. Bit 0 of the command register reads 1 from the next cycle until the frame ends, which is 128 half periods after the start.
- R3: A command-register write with bit 0 clear starts no frame and leaves the command register unchanged.
- R4: While busy, writes to either register are ignored. The running frame, the stored command and the data register do not change.
- R5: The MDC half period is BASE_HALF << csel system clocks, where csel is command bits [4:2]. MDC starts low, rises after one half period, and is low whenever the block is idle.
- R6: Frame bit order, sent MSB first: 32 ones, start 01, opcode (01 write, 10 read), PHY address (command bits [14:10]), register address (command bits [9:5]), turnaround, and 16 data bits. A write sends turnaround 10 followed by the data register. MDIO changes only while MDC is low.
- R7: For a write frame, the output enable is high for all 64 bits. For a read frame, it is high for bits 0..45 and low from the turnaround (bit 46) to the end. It is low when idle.
- R8: In a read frame, MDIO is sampled at each rising MDC edge of bits 48..63, MSB first. The 16-bit result is in the data register when busy clears.
- R9: The command register reads back as {PHY[14:10], REG[9:5], csel[4:2], write[1], busy[0]}. Bits above 14 read as zero. The data register (select 1) reads back in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 1 | Write target: 0 command, 1 data |
| host_wdata | input | 32 | Write data |
| host_rsel | input | 1 | Read select: 0 command, 1 data |
| host_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Some properties are checked on every cycle:
- MDC and the output enable are low whenever no frame is running.
- Busy rises only after a command write with the go bit set.
- The stored command is frozen for the whole frame.
- MDIO holds steady while MDC is high.

Other behaviour needs the bench's scenarios and its per-cycle reference model:
- the exact frame contents;
- the half-period length for each clock range;
- where the enable is released on reads;
- the captured read value;
- that writes made while busy are ignored.

// File: rtl/mdio_pkg.sv
// Shared constants, command type and frame builder for the management master.
// Assumes a standard clause-22 style 64-bit frame.
package mdio_pkg;
    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int CSEL_W     = 3;
    localparam int DATA_W     = 16;
    localparam int HOST_W     = 32;
    localparam int PRE_LEN    = 32;
    localparam int FRAME_LEN  = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
    // Command register bit positions
    localparam int CMD_GO     = 0;
    localparam int CMD_WR     = 1;
    localparam int CMD_CSEL   = 2;
    localparam int CMD_REG    = CMD_CSEL + CSEL_W;
    localparam int CMD_PHY    = CMD_REG + REG_W;
    localparam int CMD_TOP    = CMD_PHY + PHY_W;
    // Frame bit indices (0 = first bit sent)
    localparam int TA_BIT     = PRE_LEN + 4 + PHY_W + REG_W;
    localparam int DAT_BIT    = TA_BIT + 2;

    typedef struct packed {
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regad;
        logic [CSEL_W-1:0] csel;
        logic              wr;
    } mdio_cmd_t;

    // Assemble the whole frame, first bit in the MSB
    function automatic logic [FRAME_LEN-1:0] build_frame(mdio_cmd_t c, logic [DATA_W-1:0] d);
        logic [1:0] op;
        logic [1:0] ta;
        logic [DATA_W-1:0] payload;
        op      = c.wr ? 2'b01 : 2'b10;
        ta      = c.wr ? 2'b10 : 2'b11;
        payload = c.wr ? d : {DATA_W{1'b1}};
        return {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.regad, ta, payload};
    endfunction
endpackage

// File: rtl/mdio_host_regs.sv
// Host register file: command and data registers, start decode, read mux.
// Assumes writes are single-cycle strobes; writes are ignored while busy.
module mdio_host_regs
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 sel,
    input  logic [HOST_W-1:0]    wdata,
    input  logic                 rsel,
    output logic [HOST_W-1:0]    rdata,
    input  logic                 busy,
    input  logic                 done,
    input  logic [DATA_W-1:0]    rx_data,
    output logic                 start,
    output mdio_cmd_t            next_cmd,
    output mdio_cmd_t            cmd,
    output logic [DATA_W-1:0]    data
);
    logic unused_wdata;

    assign unused_wdata = ^wdata[HOST_W-1:CMD_TOP];

    // Decode a command word written by the host
    always_comb begin
        next_cmd.phy   = wdata[CMD_PHY +: PHY_W];
        next_cmd.regad = wdata[CMD_REG +: REG_W];
        next_cmd.csel  = wdata[CMD_CSEL +: CSEL_W];
        next_cmd.wr    = wdata[CMD_WR];
    end

    assign start = we && !sel && wdata[CMD_GO] && !busy;

    // Command register: loaded only when a frame starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= '0;
        end else if (start) begin
            cmd <= next_cmd;
        end
    end

    // Data register: host load when idle, capture at the end of a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (we && sel && !busy) begin
            data <= wdata[DATA_W-1:0];
        end else if (done && !cmd.wr) begin
            data <= rx_data;
        end
    end

    // Read-back multiplexer
    always_comb begin
        rdata = '0;
        if (rsel) begin
            rdata[DATA_W-1:0] = data;
        end else begin
            rdata[CMD_GO]               = busy;
            rdata[CMD_WR]               = cmd.wr;
            rdata[CMD_CSEL +: CSEL_W]   = cmd.csel;
            rdata[CMD_REG +: REG_W]     = cmd.regad;
            rdata[CMD_PHY +: PHY_W]     = cmd.phy;
        end
    end
endmodule

// File: rtl/mdio_mdc_gen.sv
// MDC generator: divides the system clock by a range-selected half period.
// Assumes csel stays constant while run is high; MDC is held low when idle.
module mdio_mdc_gen #(
    parameter int BASE_HALF = 1,
    parameter int CSEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CSEL_W-1:0] csel,
    output logic              mdc,
    output logic              rise,
    output logic              fall
);
    localparam int MAX_SHIFT = (1 << CSEL_W) - 1;
    localparam int HALF_W    = $clog2(BASE_HALF + 1) + MAX_SHIFT + 1;

    logic [HALF_W-1:0] half;
    logic [HALF_W-1:0] div_cnt;
    logic              toggle;

    assign half   = HALF_W'(BASE_HALF) << csel;
    assign toggle = run && (div_cnt == half - HALF_W'(1));
    assign rise   = toggle && !mdc;
    assign fall   = toggle && mdc;

    // Half-period counter and MDC level
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            mdc     <= 1'b0;
        end else if (toggle) begin
            div_cnt <= '0;
            mdc     <= !mdc;
        end else begin
            div_cnt <= div_cnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer: shifts the frame out on falling MDC, samples read data on
// rising MDC, and controls the MDIO output enable.
// Assumes start only arrives while idle.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  mdio_cmd_t            load_cmd,
    input  logic [DATA_W-1:0]    load_data,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 done,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic [DATA_W-1:0]    rx_data
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(TA_BIT);
    localparam logic [IDX_W-1:0] SMP_IDX  = IDX_W'(DAT_BIT);

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

    seq_state_t           state;
    logic [IDX_W-1:0]     idx;
    logic [FRAME_LEN-1:0] sh;
    logic                 is_wr;

    assign busy    = (state == SEQ_RUN);
    assign done    = busy && fall && (idx == LAST_IDX);
    assign mdio_oe = busy && (is_wr || (idx < REL_IDX));
    assign mdio_o  = mdio_oe && sh[FRAME_LEN-1];

    // Frame state, bit index and output shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            idx   <= '0;
            sh    <= '0;
            is_wr <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_RUN;
                        idx   <= '0;
                        sh    <= build_frame(load_cmd, load_data);
                        is_wr <= load_cmd.wr;
                    end
                end
                SEQ_RUN: begin
                    if (fall) begin
                        if (idx == LAST_IDX) begin
                            state <= SEQ_IDLE;
                        end else begin
                            idx <= idx + IDX_W'(1);
                            sh  <= {sh[FRAME_LEN-2:0], 1'b0};
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Read data capture on rising MDC in the data field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (busy && rise && !is_wr && (idx >= SMP_IDX)) begin
            rx_data <= {rx_data[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
// Top: host registers, MDC generator and frame sequencer.
// Assumes an external pad combines mdio_o/mdio_oe/mdio_i into one line.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int BASE_HALF = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    input  logic        host_rsel,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t         next_cmd;
    mdio_cmd_t         cmd;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] rx_data;
    logic              start;
    logic              seq_busy;
    logic              seq_done;
    logic              mdc_rise;
    logic              mdc_fall;
    logic [$bits(mdio_cmd_t)-1:0] cmd_view;

    assign cmd_view = cmd;

    mdio_host_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (host_we),
        .sel      (host_sel),
        .wdata    (host_wdata),
        .rsel     (host_rsel),
        .rdata    (host_rdata),
        .busy     (seq_busy),
        .done     (seq_done),
        .rx_data  (rx_data),
        .start    (start),
        .next_cmd (next_cmd),
        .cmd      (cmd),
        .data     (data)
    );

    mdio_mdc_gen #(
        .BASE_HALF (BASE_HALF),
        .CSEL_W    (CSEL_W)
    ) u_mdc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_busy),
        .csel  (cmd.csel),
        .mdc   (mdc),
        .rise  (mdc_rise),
        .fall  (mdc_fall)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_cmd  (next_cmd),
        .load_data (data),
        .rise      (mdc_rise),
        .fall      (mdc_fall),
        .mdio_i    (mdio_i),
        .busy      (seq_busy),
        .done      (seq_done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rx_data   (rx_data)
    );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
// Checker for the management master; attached by bind below.
// Assumes the top-level signal names used in the bind statement.
module mdio_mgmt_master_chk #(
    parameter int CMD_BITS = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                mdc,
    input logic                mdio_o,
    input logic                mdio_oe,
    input logic                host_we,
    input logic                host_sel,
    input logic                go_bit,
    input logic [CMD_BITS-1:0] cmd_view
);
    a_r5_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r7_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    a_r2_start_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(host_we && !host_sel && go_bit));

    a_r4_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_view));

    a_r6_steady_while_mdc_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.CMD_BITS($bits(cmd_view))) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (seq_busy),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .host_we  (host_we),
    .host_sel (host_sel),
    .go_bit   (host_wdata[0]),
    .cmd_view (cmd_view)
);

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_rsel = 1'b0;
    logic [31:0] host_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;

    // Reference model state
    bit          m_active = 0;
    int          m_t = 0;
    int          m_half = 1;
    bit          m_wr = 0;
    logic [63:0] m_frame = '0;
    logic [15:0] m_data = '0;
    logic [13:0] m_cmd = '0;
    logic [15:0] phy_resp = '0;
    bit          cmp_on = 0;

    always #2 clk = !clk;

    mdio_mgmt_master uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rsel(host_rsel), .host_rdata(host_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model advanced on each rising clock
    always @(posedge clk) begin
        bit was_active;
        was_active = m_active;
        if (!rst_n) begin
            m_active = 0; m_t = 0; m_data = '0; m_cmd = '0;
        end else begin
            if (m_active) begin
                m_t++;
                if (m_t == 128 * m_half) begin
                    m_active = 0;
                    if (!m_wr) m_data = phy_resp;
                end
            end
            if (host_we && !was_active) begin
                if (host_sel) m_data = host_wdata[15:0];
                else if (host_wdata[0]) begin
                    m_active = 1; m_t = 0;
                    m_wr   = host_wdata[1];
                    m_half = 1 << host_wdata[4:2];
                    m_cmd  = host_wdata[14:1];
                    m_frame = {32'hFFFF_FFFF, 2'b01, m_wr ? 2'b01 : 2'b10,
                               host_wdata[14:10], host_wdata[9:5],
                               m_wr ? 2'b10 : 2'b11, m_wr ? m_data : 16'hFFFF};
                end
            end
        end
    end

    // PHY stand-in: returns phy_resp bits during the read data field
    always @(negedge clk) begin
        int b;
        b = m_t / (2 * m_half);
        if (m_active && !m_wr && b >= 48) mdio_i <= phy_resp[63 - b];
        else mdio_i <= 1'b1;
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        int p;
        int b;
        #1;
        if (rst_n && cmp_on) begin
            p = m_t / m_half;
            b = p / 2;
            if (m_active) begin
                check("R5 mdc", {31'b0, mdc}, {31'b0, p[0]});
                check("R7 oe", {31'b0, mdio_oe}, {31'b0, (m_wr || b < 46)});
                if (mdio_oe) check("R6 mdio", {31'b0, mdio_o}, {31'b0, m_frame[63 - b]});
            end else begin
                check("R5 mdc idle", {31'b0, mdc}, 32'd0);
                check("R7 oe idle", {31'b0, mdio_oe}, 32'd0);
            end
            if (!host_rsel) check("R2 busy", {31'b0, host_rdata[0]}, {31'b0, m_active});
        end
    end

    task automatic host_write(logic sel, logic [31:0] w);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic logic [31:0] cmd_word(logic go, logic wr, logic [2:0] cs,
                                             logic [4:0] phy, logic [4:0] rg);
        return {17'b0, phy, rg, cs, wr, go};
    endfunction

    task automatic read_reg(logic sel, output logic [31:0] v);
        @(negedge clk);
        host_rsel = sel;
        #1 v = host_rdata;
        @(negedge clk);
        host_rsel = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_active) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        check("R1 mdc", {31'b0, mdc}, 32'd0);
        check("R1 oe", {31'b0, mdio_oe}, 32'd0);
        read_reg(1'b0, v); check("R1 cmd reg", v, 32'd0);
        read_reg(1'b1, v); check("R1 data reg", v, 32'd0);
        cmp_on = 1;

        // R3 go bit clear: no frame, command unchanged
        host_write(1'b0, cmd_word(1'b0, 1'b1, 3'd2, 5'h07, 5'h03));
        repeat (6) @(negedge clk);
        read_reg(1'b0, v); check("R3 cmd unchanged", v, 32'd0);

        // R6 R7 write frame, fastest range
        host_write(1'b1, 32'h0000_A55A);
        host_write(1'b0, cmd_word(1'b1, 1'b1, 3'd0, 5'h11, 5'h0A));
        wait_idle();
        read_reg(1'b0, v); check("R9 cmd readback", v, cmd_word(1'b0, 1'b1, 3'd0, 5'h11, 5'h0A));

        // R4 writes while busy ignored
        host_write(1'b1, 32'h0000_1234);
        host_write(1'b0, cmd_word(1'b1, 1'b1, 3'd1, 5'h02, 5'h15));
        repeat (20) @(negedge clk);
        host_write(1'b1, 32'h0000_FFFF);
        host_write(1'b0, cmd_word(1'b1, 1'b0, 3'd0, 5'h1F, 5'h1F));
        wait_idle();
        read_reg(1'b1, v); check("R4 data kept", v, 32'h0000_1234);
        read_reg(1'b0, v); check("R4 cmd kept", v, cmd_word(1'b0, 1'b1, 3'd1, 5'h02, 5'h15));

        // R8 reads at several ranges
        phy_resp = 16'h3C96;
        host_write(1'b0, cmd_word(1'b1, 1'b0, 3'd1, 5'h05, 5'h01));
        wait_idle();
        read_reg(1'b1, v); check("R8 read value csel1", v, {16'b0, 16'h3C96});

        phy_resp = 16'h8001;
        host_write(1'b0, cmd_word(1'b1, 1'b0, 3'd2, 5'h1F, 5'h1F));
        wait_idle();
        read_reg(1'b1, v); check("R8 read value csel2", v, {16'b0, 16'h8001});
        read_reg(1'b0, v); check("R9 read cmd", v, cmd_word(1'b0, 1'b0, 3'd2, 5'h1F, 5'h1F));

        host_write(1'b1, 32'h0000_0000);
        host_write(1'b0, cmd_word(1'b1, 1'b1, 3'd3, 5'h00, 5'h00));
        wait_idle();

        // R5 slowest range
        phy_resp = 16'h5AA5;
        host_write(1'b0, cmd_word(1'b1, 1'b0, 3'd7, 5'h0C, 5'h12));
        wait_idle();
        read_reg(1'b1, v); check("R8 read value csel7", v, {16'b0, 16'h5AA5});

        cmp_on = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule